// File: doc/BRIEF.md
# Conditional Execution Gate with Flag Store

This block holds the four processor status flags and decides, once per instruction, whether that instruction may act. A 4-bit condition field from the instruction is tested against the flags already stored. The result gates three side-effect requests from the instruction decoder: register write, memory write and redirecting the program counter. A request that arrives while the condition fails is dropped. The block is placed between the decoder and the state-changing parts of a single-cycle core.

The flags are reloaded from the flags that the arithmetic unit produces for the current instruction. A 2-bit write enable picks which flag groups load. This load also depends on the condition result, so an instruction that fails its condition cannot change the flags. The condition is always tested against the flags from before the current instruction. New flag values take effect from the next clock edge on.

Top module: `cond_exec_unit`

## Requirements
- R1: A synchronous reset clears all four stored flags to zero. Right after reset, condition NE (0001) passes and EQ (0000) fails.
- R2: Each output is its request AND the condition result: `pc_sel_o` = `pc_req_i`, `reg_wr_o` = `reg_req_i` and `mem_wr_o` = `mem_req_i`, each only while the condition passes. Every output is 0 while its request is 0.
- R3: Code 1110 (always) passes for every flag value.
- R4: The single-flag codes test the flags N=bit3, Z=bit2, C=bit1 and V=bit0 of the store. The true states are: 0000 Z set, 0001 Z clear, 0010 C set, 0011 C clear, 0100 N set, 0101 N clear, 0110 V set, 0111 V clear.
- R5: The compound codes are: 1000 passes when C is set and Z is clear; 1001 passes when C is clear or Z is set; 1010 passes when N equals V; 1011 passes when N differs from V; 1100 passes when Z is clear and N equals V; 1101 passes when Z is set or N differs from V.
- R6: When the condition passes and `flag_wr_i[1]` is 1, N and Z load from `alu_flags_i[3:2]` on the rising edge.
- R7: When the condition passes and `flag_wr_i[0]` is 1, C and V load from `alu_flags_i[1:0]` on the rising edge.
- R8: When the condition fails, or when the matching `flag_wr_i` bit is 0, the stored flags keep their values.
- R9: The condition is tested against the stored flags and never against `alu_flags_i` of the same cycle. A flag update first affects the next instruction.
- R10: Code 1111 passes in the default configuration (`TOP_CODE_PASSES` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition field of the current instruction |
| alu_flags_i | input | 4 | Flags from the arithmetic unit, {N,Z,C,V} |
| flag_wr_i | input | 2 | Group load enable: bit1 for N/Z, bit0 for C/V |
| pc_req_i | input | 1 | Decoder request to redirect the PC |
| reg_req_i | input | 1 | Decoder request to write a register |
| mem_req_i | input | 1 | Decoder request to write memory |
| pc_sel_o | output | 1 | Gated PC redirect |
| reg_wr_o | output | 1 | Gated register write |
| mem_wr_o | output | 1 | Gated memory write |

## Verification
The bound checker tests on every cycle that:
- no output is raised without its request, and no request is passed through on a failing condition;
- the always code passes;
- reset leaves the flags at zero;
- each flag group loads exactly when the condition passes and its enable bit is set, and holds otherwise.

The checker cannot show whether each of the sixteen codes decodes correctly over all sixteen flag states. The bench's reference model covers that with a full sweep. It also covers the ordering case where a passing instruction writes flags that its own condition must not see.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;

   typedef enum logic [3:0] {
      CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
      CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
      CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
      CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
   } cond_code_e;

   // status flags, most significant first
   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
   import cond_exec_pkg::*;
#(
   parameter bit TOP_CODE_PASSES = 1'b1
) (
   input  logic [3:0] code,
   input  flags_t     fl,
   output logic       pass
);

   logic nv_val;
   logic n_eq_v;

   generate
      if (TOP_CODE_PASSES) begin : g_top_on
         assign nv_val = 1'b1;
      end else begin : g_top_off
         assign nv_val = 1'b0;
      end
   endgenerate

   assign n_eq_v = (fl.n == fl.v);

   always_comb begin
      unique case (cond_code_e'(code))
         CC_EQ:   pass = fl.z;
         CC_NE:   pass = !fl.z;
         CC_CS:   pass = fl.c;
         CC_CC:   pass = !fl.c;
         CC_MI:   pass = fl.n;
         CC_PL:   pass = !fl.n;
         CC_VS:   pass = fl.v;
         CC_VC:   pass = !fl.v;
         CC_HI:   pass = fl.c && !fl.z;
         CC_LS:   pass = !fl.c || fl.z;
         CC_GE:   pass = n_eq_v;
         CC_LT:   pass = !n_eq_v;
         CC_GT:   pass = !fl.z && n_eq_v;
         CC_LE:   pass = fl.z || !n_eq_v;
         CC_AL:   pass = 1'b1;
         default: pass = nv_val;
      endcase
   end

endmodule

// File: rtl/flag_store.sv
module flag_store #(
   parameter int NFLAGS  = 4,
   parameter int NGROUPS = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [NGROUPS-1:0] grp_wr,
   input  logic [NFLAGS-1:0]  din,
   output logic [NFLAGS-1:0]  q
);

   localparam int GW = NFLAGS / NGROUPS;

   generate
      if (NFLAGS % NGROUPS != 0) begin : g_bad_split
         $error("flag_store: NFLAGS must divide evenly into NGROUPS");
      end
   endgenerate

   genvar g;
   generate
      for (g = 0; g < NGROUPS; g++) begin : g_grp
         logic [GW-1:0] grp_q;
         always_ff @(posedge clk) begin
            if (rst)
               grp_q <= '0;
            else if (en && grp_wr[g])
               grp_q <= din[g*GW +: GW];
         end
         assign q[g*GW +: GW] = grp_q;
      end
   endgenerate

endmodule

// File: rtl/req_gate.sv
module req_gate #(
   parameter int NREQ = 3
) (
   input  logic [NREQ-1:0] req,
   input  logic            pass,
   output logic [NREQ-1:0] grant
);

   genvar i;
   generate
      for (i = 0; i < NREQ; i++) begin : g_req
         assign grant[i] = req[i] & pass;
      end
   endgenerate

endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
   import cond_exec_pkg::*;
#(
   parameter int COND_W          = 4,
   parameter int NFLAGS          = 4,
   parameter int NGROUPS         = 2,
   parameter bit TOP_CODE_PASSES = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [3:0] cond_i,
   input  logic [3:0] alu_flags_i,
   input  logic [1:0] flag_wr_i,
   input  logic       pc_req_i,
   input  logic       reg_req_i,
   input  logic       mem_req_i,
   output logic       pc_sel_o,
   output logic       reg_wr_o,
   output logic       mem_wr_o
);

   localparam int NREQ = 3;

   generate
      if (COND_W != 4) begin : g_bad_cond
         $error("cond_exec_unit: COND_W must be 4");
      end
      if (NFLAGS != $bits(flags_t)) begin : g_bad_flags
         $error("cond_exec_unit: NFLAGS must match flags_t");
      end
      if (NGROUPS != 2) begin : g_bad_groups
         $error("cond_exec_unit: NGROUPS must be 2");
      end
   endgenerate

   logic [NFLAGS-1:0] flags_q;
   logic              cond_pass;
   logic [NREQ-1:0]   grants;

   cond_eval #(
      .TOP_CODE_PASSES(TOP_CODE_PASSES)
   ) u_eval (
      .code (cond_i),
      .fl   (flags_t'(flags_q)),
      .pass (cond_pass)
   );

   flag_store #(
      .NFLAGS (NFLAGS),
      .NGROUPS(NGROUPS)
   ) u_flags (
      .clk   (clk),
      .rst   (rst),
      .en    (cond_pass),
      .grp_wr(flag_wr_i),
      .din   (alu_flags_i),
      .q     (flags_q)
   );

   req_gate #(
      .NREQ(NREQ)
   ) u_gate (
      .req  ({pc_req_i, reg_req_i, mem_req_i}),
      .pass (cond_pass),
      .grant(grants)
   );

   assign {pc_sel_o, reg_wr_o, mem_wr_o} = grants;

endmodule

// File: rtl/cond_exec_chk.sv
module cond_exec_chk (
   input logic       clk,
   input logic       rst,
   input logic [3:0] cond_i,
   input logic [3:0] alu_flags_i,
   input logic [1:0] flag_wr_i,
   input logic       pc_req_i,
   input logic       reg_req_i,
   input logic       mem_req_i,
   input logic       pc_sel_o,
   input logic       reg_wr_o,
   input logic       mem_wr_o,
   input logic       cond_pass,
   input logic [3:0] flags_q
);

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
      (pc_sel_o || reg_wr_o || mem_wr_o) |->
      ((!pc_sel_o || pc_req_i) && (!reg_wr_o || reg_req_i) && (!mem_wr_o || mem_req_i)));

   assert_fail_blocks_R2: assert property (@(posedge clk) disable iff (rst)
      !cond_pass |-> (!pc_sel_o && !reg_wr_o && !mem_wr_o));

   assert_always_code_R3: assert property (@(posedge clk) disable iff (rst)
      (cond_i == 4'he) |-> (pc_sel_o == pc_req_i && reg_wr_o == reg_req_i && mem_wr_o == mem_req_i));

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (flags_q == 4'h0));

   assert_nz_load_R6: assert property (@(posedge clk) disable iff (rst)
      (cond_pass && flag_wr_i[1]) |=> (flags_q[3:2] == $past(alu_flags_i[3:2])));

   assert_cv_load_R7: assert property (@(posedge clk) disable iff (rst)
      (cond_pass && flag_wr_i[0]) |=> (flags_q[1:0] == $past(alu_flags_i[1:0])));

   assert_hold_fail_R8: assert property (@(posedge clk) disable iff (rst)
      !cond_pass |=> $stable(flags_q));

   assert_hold_nz_R8: assert property (@(posedge clk) disable iff (rst)
      !flag_wr_i[1] |=> $stable(flags_q[3:2]));

   assert_hold_cv_R8: assert property (@(posedge clk) disable iff (rst)
      !flag_wr_i[0] |=> $stable(flags_q[1:0]));

endmodule

bind cond_exec_unit cond_exec_chk u_chk (.*);

// File: tb/test_cond_exec_unit.sv
module test_cond_exec_unit;

   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] cond_i = 4'h0;
   logic [3:0] alu_flags_i = 4'h0;
   logic [1:0] flag_wr_i = 2'b00;
   logic       pc_req_i = 1'b0;
   logic       reg_req_i = 1'b0;
   logic       mem_req_i = 1'b0;
   logic       pc_sel_o, reg_wr_o, mem_wr_o;

   int total = 0;
   int bad = 0;
   logic [3:0] model_fl = 4'h0;   // {N,Z,C,V}

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_exec_unit i_cond_exec_unit (
      .clk(clk), .rst(rst), .cond_i(cond_i), .alu_flags_i(alu_flags_i),
      .flag_wr_i(flag_wr_i), .pc_req_i(pc_req_i), .reg_req_i(reg_req_i),
      .mem_req_i(mem_req_i), .pc_sel_o(pc_sel_o), .reg_wr_o(reg_wr_o),
      .mem_wr_o(mem_wr_o)
   );

   function automatic bit ref_pass(input logic [3:0] c, input logic [3:0] f);
      bit n = f[3], z = f[2], cy = f[1], v = f[0];
      case (c)
         0: return z;          1: return !z;
         2: return cy;         3: return !cy;
         4: return n;          5: return !n;
         6: return v;          7: return !v;
         8: return cy && !z;   9: return !cy || z;
         10: return n == v;    11: return n != v;
         12: return !z && (n == v);
         13: return z || (n != v);
         default: return 1'b1; // 14 always, 15 passes by default (R10)
      endcase
   endfunction

   function automatic string code_tag(input logic [3:0] c);
      if (c < 8) return "R4";
      if (c < 14) return "R5";
      if (c == 14) return "R3";
      return "R10";
   endfunction

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s cond=%h flags=%b: {pc,reg,mem} actual=%b expected=%b",
                  tag, cond_i, model_fl, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] c, input logic [3:0] alu, input logic [1:0] fw,
                       input logic [2:0] reqs, input string tag);
      bit p;
      @(negedge clk);
      cond_i = c; alu_flags_i = alu; flag_wr_i = fw;
      {pc_req_i, reg_req_i, mem_req_i} = reqs;
      #1;
      p = ref_pass(c, model_fl);
      check(tag, {pc_sel_o, reg_wr_o, mem_wr_o}, reqs & {3{p}});   // R2 gating
      @(posedge clk);
      if (p && fw[1]) model_fl[3:2] = alu[3:2];
      if (p && fw[0]) model_fl[1:0] = alu[1:0];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      model_fl = 4'h0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1: cleared flags
      step(4'h1, 4'hf, 2'b00, 3'b111, "R1");
      step(4'h0, 4'hf, 2'b00, 3'b111, "R1");

      // R6: N/Z group only
      step(4'he, 4'hf, 2'b10, 3'b000, "R6");
      step(4'h4, 4'h0, 2'b00, 3'b111, "R6");
      step(4'h2, 4'h0, 2'b00, 3'b111, "R6");

      // R7: C/V group only
      do_reset();
      step(4'he, 4'hf, 2'b01, 3'b101, "R7");
      step(4'h2, 4'h0, 2'b00, 3'b111, "R7");
      step(4'h4, 4'h0, 2'b00, 3'b111, "R7");

      // R8: failing condition cannot write flags
      do_reset();
      step(4'h0, 4'hf, 2'b11, 3'b111, "R8");
      step(4'h4, 4'h0, 2'b00, 3'b111, "R8");
      step(4'h6, 4'h0, 2'b00, 3'b111, "R8");
      step(4'he, 4'hf, 2'b00, 3'b010, "R8");
      step(4'h5, 4'h0, 2'b00, 3'b111, "R8");

      // R9: own flag update not seen by own condition
      do_reset();
      step(4'h1, 4'h4, 2'b10, 3'b111, "R9");
      step(4'h1, 4'h0, 2'b00, 3'b111, "R9");
      step(4'h0, 4'h0, 2'b00, 3'b111, "R9");

      // full sweep of flag states and codes with varied requests
      for (int f = 0; f < 16; f++) begin
         step(4'he, 4'(f), 2'b11, 3'(f), "R3");
         for (int c = 0; c < 16; c++)
            step(4'(c), 4'(~f), 2'b00, 3'(c + f), code_tag(4'(c)));
      end

      // R2: requests low with passing condition
      step(4'he, 4'h0, 2'b00, 3'b000, "R2");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule